// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherent Cache Cluster

This block joins a small group of processor ports to one shared word memory. Each port has its own private, direct-mapped, write-through cache. A single shared bus carries one transaction per cycle; a round-robin arbiter picks which cache owns the bus in a given cycle. Reads that hit are served locally in one cycle and never touch the bus. Read misses and every write, whether it hits or misses, go out on the bus.

Every cache watches the writes that the other caches put on the bus. When a write's block address matches a valid line that a cache holds, that cache drops the line. Many caches may therefore hold the same block while it is only read, but after a write only the writer's copy stays valid. Coherence is tracked per whole block, so a write to any word of a block invalidates copies held for other words of it (false sharing).

Each cache counts the invalidations it receives from snooping. It also counts coherence misses, meaning misses to a line whose tag still matches but which a snoop invalidated. Cold misses and misses that replace a different tag are not counted.

Top module: `coh_snoop_sys`

## Requirements
- R1: After reset every line is invalid, both counters of every cache are zero, `cpu_ready` is high and `cpu_done` is low. Memory word at word address a resets to 32'hC0DE0000 | a.
- R2: Word addresses split into a 3-bit word offset (bits 2:0), a 2-bit line index (bits 4:3) and a 3-bit tag (bits 7:5). An uncontended read miss raises `cpu_done` two cycles after the cycle the request was sampled, with the memory word on `cpu_rdata`. It also fills the whole 8-word block, so a later read of any word of that block hits and finishes one cycle after its request.
- R3: Several caches may hold the same block at once. Reads by one cache never invalidate another's copy.
- R4: Writes go through to memory in their bus cycle and finish two cycles after the request when uncontended. A writer holding the block updates its own copy, so its later read hits with the new value.
- R5: A write invalidates the matching valid line in every other cache and increments their invalidation counters by one each. Their next read of that block is a miss that returns the memory value.
- R6: Invalidation works per block: a write to one word invalidates a copy that was read only through other words of the same block.
- R7: A write miss does not allocate and does not evict the line at that index. A miss on a line that is not invalidated-with-matching-tag leaves the coherence-miss counter unchanged.
- R8: A bus write whose tag differs from the held line at the same index leaves that line valid and the invalidation counter unchanged.
- R9: A read hit finishes one cycle after its request even while another cache owns the bus that cycle.
- R10: At most one cache owns the bus per cycle. Misses raised by several caches in the same cycle complete on consecutive distinct cycles, one per cache.
- R11: A snoop invalidation in the same cycle as a local read hit to that block wins. The read is replayed as a miss, returns the newly written value two cycles after its request, and counts as a coherence miss.
- R12: A miss on a line whose tag matches but which was invalidated by a snoop increments that cache's coherence-miss counter by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | NCACHE | One-cycle request pulse per port, taken when ready |
| cpu_we | input | NCACHE | Request is a write when high |
| cpu_addr | input | NCACHE*ADDR_W | Word address per port |
| cpu_wdata | input | NCACHE*DATA_W | Write data per port |
| cpu_ready | output | NCACHE | Port can take a request |
| cpu_done | output | NCACHE | One-cycle completion pulse |
| cpu_rdata | output | NCACHE*DATA_W | Read result, valid with done |
| inv_count | output | NCACHE*CNT_W | Invalidations received per cache |
| cmiss_count | output | NCACHE*CNT_W | Coherence misses per cache |

## Verification
The bench builds the cluster with three caches, four lines of eight words, and an 8-bit word address. Three caches let one writer invalidate two readers at once and let three misses contend for the bus, so the round-robin order comes into play. The tiny address space lets two blocks share a line index with different tags, which makes the tag-mismatch snoop and the non-allocating write miss easy to reach. With only four lines, the replay race between a snoop and a local hit can be set up one cycle apart.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic {
        C_IDLE = 1'b0,
        C_WAIT = 1'b1
    } cstate_e;
endpackage

// File: rtl/coh_rr_arbiter.sv
module coh_rr_arbiter #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } arb_s;

    arb_s r_q, r_d;
    logic found;

    always_comb begin
        r_d   = r_q;
        grant = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(r_q.ptr) + k;
            if (j >= N) j = j - N;
            if (!found && req[j]) begin
                grant[j] = 1'b1;
                found    = 1'b1;
                r_d.ptr  = (j == N - 1) ? '0 : PTR_W'(j + 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/coh_memory.sv
module coh_memory #(
    parameter int              ADDR_W      = 8,
    parameter int              BLOCK_WORDS = 8,
    parameter int              DATA_W      = 32,
    parameter logic [DATA_W-1:0] INIT_BASE = 32'hC0DE0000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [BLOCK_WORDS*DATA_W-1:0] blk
);
    localparam int OFF_W = $clog2(BLOCK_WORDS);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[addr] = wdata;
        for (int w = 0; w < BLOCK_WORDS; w++) begin
            blk[w*DATA_W +: DATA_W] = mem_q[{addr[ADDR_W-1:OFF_W], OFF_W'(w)}];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT_BASE | DATA_W'(i);
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/coh_cache.sv
module coh_cache #(
    parameter int LINES       = 4,
    parameter int BLOCK_WORDS = 8,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_req,
    input  logic                          cpu_we,
    input  logic [ADDR_W-1:0]             cpu_addr,
    input  logic [DATA_W-1:0]             cpu_wdata,
    output logic                          cpu_ready,
    output logic                          cpu_done,
    output logic [DATA_W-1:0]             cpu_rdata,
    output logic [CNT_W-1:0]              inv_count,
    output logic [CNT_W-1:0]              cmiss_count,
    output logic                          bus_req,
    output logic                          req_we,
    output logic [ADDR_W-1:0]             req_addr,
    output logic [DATA_W-1:0]             req_wdata,
    input  logic                          bus_grant,
    input  logic                          bus_valid,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [BLOCK_WORDS*DATA_W-1:0] fill_blk
);
    import coh_pkg::*;

    localparam int OFF_W = $clog2(BLOCK_WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    typedef struct packed {
        cstate_e                                     st;
        logic                                        pend_we;
        logic [ADDR_W-1:0]                           pend_addr;
        logic [DATA_W-1:0]                           pend_wdata;
        logic                                        done;
        logic [DATA_W-1:0]                           rdata;
        logic [CNT_W-1:0]                            inv_cnt;
        logic [CNT_W-1:0]                            cm_cnt;
        logic [LINES-1:0]                            valid;
        logic [LINES-1:0]                            invd;
        logic [LINES-1:0][TAG_W-1:0]                 tag;
        logic [LINES-1:0][BLOCK_WORDS-1:0][DATA_W-1:0] data;
    } cache_s;

    cache_s r_q, r_d;

    logic [IDX_W-1:0] c_idx, s_idx, p_idx;
    logic [TAG_W-1:0] c_tag, s_tag, p_tag;
    logic [OFF_W-1:0] c_off, p_off;
    logic             c_hit, s_hit, p_hit, p_cmiss;

    always_comb begin
        c_idx = cpu_addr[OFF_W +: IDX_W];
        c_tag = cpu_addr[ADDR_W-1 -: TAG_W];
        c_off = cpu_addr[OFF_W-1:0];
        s_idx = bus_addr[OFF_W +: IDX_W];
        s_tag = bus_addr[ADDR_W-1 -: TAG_W];
        p_idx = r_q.pend_addr[OFF_W +: IDX_W];
        p_tag = r_q.pend_addr[ADDR_W-1 -: TAG_W];
        p_off = r_q.pend_addr[OFF_W-1:0];

        c_hit   = r_q.valid[c_idx] && (r_q.tag[c_idx] == c_tag);
        s_hit   = bus_valid && bus_we && !bus_grant &&
                  r_q.valid[s_idx] && (r_q.tag[s_idx] == s_tag);
        p_hit   = r_q.valid[p_idx] && (r_q.tag[p_idx] == p_tag);
        p_cmiss = r_q.invd[p_idx] && (r_q.tag[p_idx] == p_tag);

        r_d      = r_q;
        r_d.done = 1'b0;

        // Snooped write from another cache: drop a matching line.
        if (s_hit) begin
            r_d.valid[s_idx] = 1'b0;
            r_d.invd[s_idx]  = 1'b1;
            r_d.inv_cnt      = r_q.inv_cnt + 1'b1;
        end

        unique case (r_q.st)
            C_IDLE: begin
                if (cpu_req) begin
                    if (!cpu_we && c_hit && !(s_hit && (s_idx == c_idx))) begin
                        r_d.done  = 1'b1;
                        r_d.rdata = r_q.data[c_idx][c_off];
                    end else begin
                        r_d.st         = C_WAIT;
                        r_d.pend_we    = cpu_we;
                        r_d.pend_addr  = cpu_addr;
                        r_d.pend_wdata = cpu_wdata;
                    end
                end
            end
            C_WAIT: begin
                if (bus_grant) begin
                    r_d.st   = C_IDLE;
                    r_d.done = 1'b1;
                    if (r_q.pend_we) begin
                        if (p_hit) r_d.data[p_idx][p_off] = r_q.pend_wdata;
                    end else begin
                        if (p_cmiss) r_d.cm_cnt = r_q.cm_cnt + 1'b1;
                        r_d.valid[p_idx] = 1'b1;
                        r_d.invd[p_idx]  = 1'b0;
                        r_d.tag[p_idx]   = p_tag;
                        r_d.data[p_idx]  = fill_blk;
                        r_d.rdata        = fill_blk[p_off*DATA_W +: DATA_W];
                    end
                end
            end
            default: r_d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cpu_ready   = (r_q.st == C_IDLE);
    assign cpu_done    = r_q.done;
    assign cpu_rdata   = r_q.rdata;
    assign inv_count   = r_q.inv_cnt;
    assign cmiss_count = r_q.cm_cnt;
    assign bus_req     = (r_q.st == C_WAIT);
    assign req_we      = r_q.pend_we;
    assign req_addr    = r_q.pend_addr;
    assign req_wdata   = r_q.pend_wdata;
endmodule

// File: rtl/coh_snoop_sys.sv
module coh_snoop_sys #(
    parameter int NCACHE      = 3,
    parameter int LINES       = 4,
    parameter int BLOCK_WORDS = 8,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCACHE-1:0]        cpu_req,
    input  logic [NCACHE-1:0]        cpu_we,
    input  logic [NCACHE*ADDR_W-1:0] cpu_addr,
    input  logic [NCACHE*DATA_W-1:0] cpu_wdata,
    output logic [NCACHE-1:0]        cpu_ready,
    output logic [NCACHE-1:0]        cpu_done,
    output logic [NCACHE*DATA_W-1:0] cpu_rdata,
    output logic [NCACHE*CNT_W-1:0]  inv_count,
    output logic [NCACHE*CNT_W-1:0]  cmiss_count
);
    localparam int BLK_W = BLOCK_WORDS * DATA_W;

    logic [NCACHE-1:0]             bus_req;
    logic [NCACHE-1:0]             bus_grant;
    logic [NCACHE-1:0]             c_we;
    logic [NCACHE-1:0][ADDR_W-1:0] c_addr;
    logic [NCACHE-1:0][DATA_W-1:0] c_wdata;
    logic                          bus_valid;
    logic                          bus_we;
    logic [ADDR_W-1:0]             bus_addr;
    logic [DATA_W-1:0]             bus_wdata;
    logic [BLK_W-1:0]              fill_blk;

    coh_rr_arbiter #(.N(NCACHE)) arb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (bus_req),
        .grant (bus_grant)
    );

    always_comb begin
        bus_valid = |bus_grant;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        for (int i = 0; i < NCACHE; i++) begin
            if (bus_grant[i]) begin
                bus_we    = c_we[i];
                bus_addr  = c_addr[i];
                bus_wdata = c_wdata[i];
            end
        end
    end

    coh_memory #(
        .ADDR_W      (ADDR_W),
        .BLOCK_WORDS (BLOCK_WORDS),
        .DATA_W      (DATA_W)
    ) mem_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_valid && bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .blk   (fill_blk)
    );

    for (genvar g = 0; g < NCACHE; g++) begin : g_cache
        coh_cache #(
            .LINES       (LINES),
            .BLOCK_WORDS (BLOCK_WORDS),
            .ADDR_W      (ADDR_W),
            .DATA_W      (DATA_W),
            .CNT_W       (CNT_W)
        ) cache_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .cpu_req     (cpu_req[g]),
            .cpu_we      (cpu_we[g]),
            .cpu_addr    (cpu_addr[g*ADDR_W +: ADDR_W]),
            .cpu_wdata   (cpu_wdata[g*DATA_W +: DATA_W]),
            .cpu_ready   (cpu_ready[g]),
            .cpu_done    (cpu_done[g]),
            .cpu_rdata   (cpu_rdata[g*DATA_W +: DATA_W]),
            .inv_count   (inv_count[g*CNT_W +: CNT_W]),
            .cmiss_count (cmiss_count[g*CNT_W +: CNT_W]),
            .bus_req     (bus_req[g]),
            .req_we      (c_we[g]),
            .req_addr    (c_addr[g]),
            .req_wdata   (c_wdata[g]),
            .bus_grant   (bus_grant[g]),
            .bus_valid   (bus_valid),
            .bus_we      (bus_we),
            .bus_addr    (bus_addr),
            .fill_blk    (fill_blk)
        );
    end
endmodule

// File: rtl/coh_snoop_chk.sv
module coh_snoop_chk #(
    parameter int NCACHE = 3,
    parameter int CNT_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NCACHE-1:0]       bus_req,
    input logic [NCACHE-1:0]       bus_grant,
    input logic                    bus_valid,
    input logic                    bus_we,
    input logic [NCACHE-1:0]       cpu_ready,
    input logic [NCACHE-1:0]       cpu_done,
    input logic [NCACHE*CNT_W-1:0] inv_count,
    input logic [NCACHE*CNT_W-1:0] cmiss_count
);
    // R10: a single bus owner per cycle
    a_r10_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_grant));

    for (genvar i = 0; i < NCACHE; i++) begin : g_chk
        // R10: the bus is granted only to a waiting cache
        a_r10_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
            bus_grant[i] |-> bus_req[i]);
        // R2: a bus transaction completes the request on the next cycle
        a_r2_done_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
            bus_grant[i] |=> cpu_done[i]);
        // R9: a port waiting on the bus takes no new request
        a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
            bus_req[i] |-> !cpu_ready[i]);
        // R5: invalidations only come from another cache's bus write
        a_r5_inv_from_write: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_valid && bus_we && !bus_grant[i]) |=> $stable(inv_count[i*CNT_W +: CNT_W]));
        // R12: coherence misses are counted only on an own bus transaction
        a_r12_cmiss_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_grant[i] |=> $stable(cmiss_count[i*CNT_W +: CNT_W]));
    end
endmodule

bind coh_snoop_sys coh_snoop_chk #(.NCACHE(NCACHE), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_grant   (bus_grant),
    .bus_valid   (bus_valid),
    .bus_we      (bus_we),
    .cpu_ready   (cpu_ready),
    .cpu_done    (cpu_done),
    .inv_count   (inv_count),
    .cmiss_count (cmiss_count)
);

// File: tb/coh_snoop_sys_tb_top.sv
module coh_snoop_sys_tb_top;
    localparam int NC = 3;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int CW = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NC-1:0]    cpu_req = '0;
    logic [NC-1:0]    cpu_we = '0;
    logic [NC*AW-1:0] cpu_addr = '0;
    logic [NC*DW-1:0] cpu_wdata = '0;
    logic [NC-1:0]    cpu_ready;
    logic [NC-1:0]    cpu_done;
    logic [NC*DW-1:0] cpu_rdata;
    logic [NC*CW-1:0] inv_count;
    logic [NC*CW-1:0] cmiss_count;

    coh_snoop_sys #(.NCACHE(NC), .LINES(4), .BLOCK_WORDS(8), .ADDR_W(AW),
                    .DATA_W(DW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .inv_count(inv_count),
        .cmiss_count(cmiss_count)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit          rd;
        logic [31:0] d;
        string       rq;
    } exp_t;

    exp_t expq [NC][$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   lat_rec [NC];
    int   exp_inv [NC];
    int   exp_cm  [NC];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mval(input logic [7:0] a);
        return 32'hC0DE0000 | {24'h0, a};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per completion and compares the data.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NC; i++) begin
                if (cpu_done[i]) begin
                    if (expq[i].size() == 0) begin
                        chk(1'b0, "R2", "unexpected done", 32'h1, 32'h0);
                    end else begin
                        exp_t e;
                        e = expq[i].pop_front();
                        if (e.rd) chk(cpu_rdata[i*DW +: DW] == e.d, e.rq, "read data",
                                      cpu_rdata[i*DW +: DW], e.d);
                    end
                end
            end
        end
    end

    // Driver: one request on port c, pushes the expected item, measures latency.
    task automatic access(input int c, input bit we, input logic [7:0] a,
                          input logic [31:0] wd, input logic [31:0] exp,
                          input int exp_lat, input string rq);
        int start;
        int lat;
        bit seen;
        exp_t e;
        e.rd = !we; e.d = exp; e.rq = rq;
        expq[c].push_back(e);
        cpu_req[c] = 1'b1;
        cpu_we[c]  = we;
        cpu_addr[c*AW +: AW]  = a;
        cpu_wdata[c*DW +: DW] = wd;
        start = cyc;
        seen = 1'b0;
        for (int k = 0; k < 40 && !seen; k++) begin
            @(negedge clk);
            cpu_req[c] = 1'b0;
            if (cpu_done[c]) seen = 1'b1;
        end
        lat = cyc - start;
        lat_rec[c] = lat;
        if (!seen) chk(1'b0, rq, "no completion", 32'h0, 32'h1);
        else if (exp_lat > 0) chk(lat == exp_lat, rq, "latency", lat, exp_lat);
    endtask

    task automatic check_counts(input string rq);
        for (int i = 0; i < NC; i++) begin
            chk(inv_count[i*CW +: CW] == CW'(exp_inv[i]), rq, "inv_count",
                inv_count[i*CW +: CW], exp_inv[i]);
            chk(cmiss_count[i*CW +: CW] == CW'(exp_cm[i]), rq, "cmiss_count",
                cmiss_count[i*CW +: CW], exp_cm[i]);
        end
    endtask

    localparam logic [7:0] BA = 8'h20;  // index 0, tag 1
    localparam logic [7:0] BX = 8'h40;  // index 0, tag 2
    localparam logic [7:0] BC = 8'h08;  // index 1, tag 0

    initial begin
        for (int i = 0; i < NC; i++) begin exp_inv[i] = 0; exp_cm[i] = 0; lat_rec[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(cpu_ready == '1, "R1", "ready after reset", 32'(cpu_ready), 32'h7);
        chk(cpu_done == '0, "R1", "done after reset", 32'(cpu_done), 32'h0);
        check_counts("R1");

        // R1 R2: cold miss then hit in the filled block
        access(0, 1'b0, BA + 0, '0, mval(BA + 0), 2, "R2");
        access(0, 1'b0, BA + 5, '0, mval(BA + 5), 1, "R2");

        // R3: sharing by all three caches
        access(1, 1'b0, BA + 0, '0, mval(BA + 0), 2, "R3");
        access(2, 1'b0, BA + 0, '0, mval(BA + 0), 2, "R3");
        access(1, 1'b0, BA + 1, '0, mval(BA + 1), 1, "R3");
        access(2, 1'b0, BA + 2, '0, mval(BA + 2), 1, "R3");
        check_counts("R3");

        // R4 R5 R6: write to word 3 invalidates copies used through words 0..2
        access(0, 1'b1, BA + 3, 32'h1111_0003, '0, 2, "R4");
        exp_inv[1]++; exp_inv[2]++;
        check_counts("R6");
        access(0, 1'b0, BA + 3, '0, 32'h1111_0003, 1, "R4");
        access(1, 1'b0, BA + 0, '0, mval(BA + 0), 2, "R5");
        exp_cm[1]++;
        access(2, 1'b0, BA + 3, '0, 32'h1111_0003, 2, "R5");
        exp_cm[2]++;
        check_counts("R12");

        // R8: write to another tag at the same index leaves copies alone
        access(0, 1'b1, BX + 1, 32'h2222_0041, '0, 2, "R8");
        check_counts("R8");
        access(1, 1'b0, BA + 2, '0, mval(BA + 2), 1, "R8");
        // R7: that write miss did not evict or allocate in the writer
        access(0, 1'b0, BA + 3, '0, 32'h1111_0003, 1, "R7");
        access(0, 1'b0, BX + 1, '0, 32'h2222_0041, 2, "R7");
        check_counts("R7");

        // R9: a hit is served in one cycle while another cache owns the bus
        fork
            access(2, 1'b1, BC + 0, 32'h3333_0008, '0, 2, "R9");
            begin
                @(negedge clk);
                access(1, 1'b0, BA + 2, '0, mval(BA + 2), 1, "R9");
            end
        join
        check_counts("R9");

        // R10: three simultaneous misses complete on distinct consecutive cycles
        fork
            access(0, 1'b0, BC + 0, '0, 32'h3333_0008, 0, "R10");
            access(1, 1'b0, BC + 1, '0, mval(BC + 1), 0, "R10");
            access(2, 1'b0, BC + 0, '0, 32'h3333_0008, 0, "R10");
        join
        chk(lat_rec[0] + lat_rec[1] + lat_rec[2] == 9 &&
            lat_rec[0] != lat_rec[1] && lat_rec[1] != lat_rec[2] &&
            lat_rec[0] != lat_rec[2], "R10", "latency spread",
            32'(lat_rec[0] * 100 + lat_rec[1] * 10 + lat_rec[2]), 32'd234);
        check_counts("R10");

        // R11: snoop in the same cycle as a local hit replays the read as a miss
        fork
            access(0, 1'b1, BA + 0, 32'h4444_0020, '0, 2, "R11");
            begin
                @(negedge clk);
                access(1, 1'b0, BA + 0, '0, 32'h4444_0020, 2, "R11");
            end
        join
        exp_inv[1]++; exp_inv[2]++; exp_cm[1]++;
        check_counts("R11");

        repeat (3) @(negedge clk);
        for (int i = 0; i < NC; i++)
            chk(expq[i].size() == 0, "R2", "pending expectations", expq[i].size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule